// File: doc/BRIEF.md
# Transmit Frame Pad and CRC Stage

This block sits between a transmit buffer and the byte-serial MAC output. It takes the frame body as a valid/ready byte stream, passes the data bytes through unchanged, and then finishes the frame. When the body is too short it appends zero bytes. It appends the 32-bit frame check sequence unless that is switched off. Two option inputs choose the finishing steps. `pad_off` turns off padding, so short (runt) frames leave as they are. `crc_off` turns off the CRC. The two options act independently of each other.

The block samples the options with the first data byte of each frame and holds them for the rest of that frame. A `crc_bad` request on any accepted data byte makes the block append a deliberately wrong CRC. The CRC is the bitwise complement of the correct one, which lets an aborted frame be spoiled on the wire. In the data phase the block adds no latency: a data byte moves from input to output in the same cycle the handshake completes. Pad and CRC bytes are produced from internal state while the input is held off.

Top module: `txf_frame_finisher`

## Requirements
- R1: Every accepted data byte appears on `out_data` unchanged, in input order, in the cycle it is accepted. The end of the data part of a frame is marked by `in_last` on its final byte.
- R2: With `pad_off`=0 and fewer than 60 data bytes, 0x00 bytes follow the data until exactly 60 data-plus-pad bytes have been sent. With 60 or more data bytes, no pad is added.
- R3: With `pad_off`=1, no pad byte is ever emitted. A frame of any length down to one byte goes out with only its data bytes, plus the CRC if it is enabled.
- R4: With `crc_off`=0, four CRC bytes follow the data and pad bytes. The CRC is CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final complement, taken over the data and pad bytes. Bits 7:0 of the CRC are sent first and bits 31:24 last.
- R5: With `crc_off`=1, no CRC byte is emitted, whatever the `pad_off` setting.
- R6: If `crc_bad` is 1 on the handshake of any data byte of a frame, the four CRC bytes of that frame are the complement of the correct CRC value.
- R7: `out_last` is 1 on exactly one byte per frame. That byte is the final byte emitted, whether it is a data, pad or CRC byte.
- R8: While `out_valid`=1 and `out_ready`=0 during the pad or CRC phase, `out_valid` stays 1 and `out_data` keeps its value in the next cycle. No byte is lost or repeated. During the data phase, `in_ready` equals `out_ready`.
- R9: `pad_off` and `crc_off` are sampled on the handshake of the first data byte of a frame. Changing them later in that frame has no effect on its pad or CRC bytes.
- R10: While reset is applied and until it has been released for two clock edges, `in_ready` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_off | input | 1 | 1 disables padding to the minimum body size |
| crc_off | input | 1 | 1 disables the appended CRC |
| crc_bad | input | 1 | Request to corrupt this frame's CRC, sampled with each data byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input data byte |
| in_last | input | 1 | Marks the final data byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final emitted byte of a frame |

## Verification
The assertions check, on every cycle, the structural rules of the sequencer. The pad and CRC phases are never entered against the frame's latched options. A padded frame reaches the CRC phase only with the counter at the minimum body size. A frame end always returns the block to its idle data phase. A stalled pad or CRC byte holds its state. Only the bench's scenarios can show that the byte values are right. The correct CRC, its complemented form, the exact pad count for bodies of 1, 59, 60 and 61 bytes, and the position of `out_last` all depend on whole-frame contents. The bench also shows that option changes in the middle of a frame are ignored.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;

  localparam int CRC_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int CRC_BYTES = CRC_W / BYTE_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_CRC  = 2'd2
  } txf_state_e;

  // One byte of the reflected CRC-32, least significant bit first.
  function automatic logic [CRC_W-1:0] crc32_byte(input logic [CRC_W-1:0] c,
                                                   input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int k = 0; k < BYTE_W; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/txf_crc_acc.sv
`timescale 1ns/1ps
module txf_crc_acc
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  always_comb begin
    crc_en = init | upd;
    crc_d  = crc_q;
    if (init) begin
      crc_d = CRC_SEED;
    end else if (upd) begin
      crc_d = crc32_byte(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/txf_seq.sv
`timescale 1ns/1ps
module txf_seq
  import txf_pkg::*;
#(
  parameter int MIN_BODY = 60,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pad_off,
  input  logic             crc_off,
  input  logic             crc_bad,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output txf_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             bad_o,
  output logic             crc_upd,
  output logic             crc_init
);

  localparam int              CNT_W    = $clog2(MIN_BODY + 1);
  localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_BODY);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(MIN_BODY - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CRC_BYTES - 1);

  txf_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bad_q, bad_d;
  logic             pad_off_q, crc_off_q;
  logic             opt_en;
  logic             first;
  logic             pad_off_e, crc_off_e;
  logic             need_pad;
  logic             hs_out;
  logic             frame_end;
  logic [CNT_W-1:0] cnt_inc;

  // Option view: live on the first byte, latched for the remainder.
  always_comb begin
    first     = (state_q == ST_DATA) && (cnt_q == '0);
    pad_off_e = first ? pad_off : pad_off_q;
    crc_off_e = first ? crc_off : crc_off_q;
    need_pad  = !pad_off_e && (cnt_q < CNT_PRE);
    cnt_inc   = (cnt_q == CNT_MIN) ? CNT_MIN : cnt_q + 1'b1;
  end

  // Handshake outputs.
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        in_ready  = run && out_ready;
        out_valid = run && in_valid;
        out_last  = in_last && !need_pad && crc_off_e;
      end
      ST_PAD: begin
        out_valid = run;
        out_last  = (cnt_q == CNT_PRE) && crc_off_q;
      end
      ST_CRC: begin
        out_valid = run;
        out_last  = (idx_q == IDX_LAST);
      end
      default: begin
        out_valid = 1'b0;
      end
    endcase
    hs_out = out_valid && out_ready;
  end

  // Next state.
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    bad_d     = bad_q;
    opt_en    = 1'b0;
    crc_upd   = 1'b0;
    frame_end = 1'b0;
    if (hs_out) begin
      unique case (state_q)
        ST_DATA: begin
          crc_upd = 1'b1;
          cnt_d   = cnt_inc;
          bad_d   = bad_q | crc_bad;
          opt_en  = first;
          if (in_last) begin
            if (need_pad)        state_d = ST_PAD;
            else if (!crc_off_e) state_d = ST_CRC;
            else                 frame_end = 1'b1;
          end
        end
        ST_PAD: begin
          crc_upd = 1'b1;
          cnt_d   = cnt_inc;
          if (cnt_q == CNT_PRE) begin
            if (crc_off_q) frame_end = 1'b1;
            else           state_d = ST_CRC;
          end
        end
        ST_CRC: begin
          if (idx_q == IDX_LAST) frame_end = 1'b1;
          else                   idx_d = idx_q + 1'b1;
        end
        default: begin
          state_d = ST_DATA;
        end
      endcase
    end
    if (frame_end) begin
      state_d = ST_DATA;
      cnt_d   = '0;
      idx_d   = '0;
      bad_d   = 1'b0;
    end
    crc_init = frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DATA;
      cnt_q   <= '0;
      idx_q   <= '0;
      bad_q   <= 1'b0;
    end else if (hs_out) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      bad_q   <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_off_q <= 1'b0;
      crc_off_q <= 1'b0;
    end else if (opt_en) begin
      pad_off_q <= pad_off;
      crc_off_q <= crc_off;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign bad_o   = bad_q;

  // Pad phase only exists for frames whose latched options allow it (R3).
  p_pad_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |-> !pad_off_q);

  // CRC phase never appears for a frame with CRC switched off (R5).
  p_crc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC) |-> !crc_off_q);

  // A padded frame enters the CRC phase only with the full minimum body (R2).
  p_min_body_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC && !pad_off_q) |-> (cnt_q == CNT_MIN));

  // The last-flagged byte always returns the block to an empty frame (R7).
  p_end_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=>
      (state_q == ST_DATA && cnt_q == '0 && idx_q == '0 && !bad_q));

  // A stalled generated byte keeps its position (R8).
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && state_q != ST_DATA) |=>
      (out_valid && $stable(state_q) && $stable(cnt_q) && $stable(idx_q)));

endmodule

// File: rtl/txf_byte_mux.sv
`timescale 1ns/1ps
module txf_byte_mux
  import txf_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  txf_state_e        state,
  input  logic [IDX_W-1:0]  idx,
  input  logic              bad,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [CRC_W-1:0]  crc,
  output logic [BYTE_W-1:0] out_data
);

  logic [CRC_W-1:0]  fcs;
  logic [BYTE_W-1:0] fcs_b [CRC_BYTES];

  // Normal frames send the complemented register; a spoiled frame sends it raw.
  assign fcs = bad ? crc : ~crc;

  for (genvar g = 0; g < CRC_BYTES; g++) begin : g_fcs
    assign fcs_b[g] = fcs[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (state)
      ST_PAD:  out_data = '0;
      ST_CRC:  out_data = fcs_b[idx];
      default: out_data = in_data;
    endcase
  end

endmodule

// File: rtl/txf_frame_finisher.sv
`timescale 1ns/1ps
module txf_frame_finisher
  import txf_pkg::*;
#(
  parameter int MIN_BODY = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_off,
  input  logic       crc_off,
  input  logic       crc_bad,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);

  localparam int IDX_W = $clog2(CRC_BYTES);

  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  txf_state_e         state;
  logic [IDX_W-1:0]   idx;
  logic               bad;
  logic               crc_upd;
  logic               crc_init;
  logic [BYTE_W-1:0]  crc_din;
  logic [CRC_W-1:0]   crc;

  // Asynchronous assertion, synchronous two-stage release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  assign crc_din = (state == ST_PAD) ? '0 : in_data;

  txf_seq #(
    .MIN_BODY (MIN_BODY),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .run       (rst_i_n),
    .pad_off   (pad_off),
    .crc_off   (crc_off),
    .crc_bad   (crc_bad),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .state_o   (state),
    .idx_o     (idx),
    .bad_o     (bad),
    .crc_upd   (crc_upd),
    .crc_init  (crc_init)
  );

  txf_crc_acc u_crc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .init  (crc_init),
    .upd   (crc_upd),
    .din   (crc_din),
    .crc_o (crc)
  );

  txf_byte_mux #(
    .IDX_W (IDX_W)
  ) u_mux (
    .state    (state),
    .idx      (idx),
    .bad      (bad),
    .in_data  (in_data),
    .crc      (crc),
    .out_data (out_data)
  );

  // Nothing is offered or accepted while the internal reset is held (R10).
  always @(posedge clk) begin
    if (!rst_i_n) begin
      p_reset_quiet_r10: assert (!in_ready && !out_valid);
    end
  end

endmodule

// File: tb/tb_txf_frame_finisher.sv
`timescale 1ns/1ps
module tb_txf_frame_finisher;

  localparam int NF   = 48;
  localparam int MINB = 60;
  localparam int WD   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pad_off, crc_off, crc_bad;
  logic       in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  txf_frame_finisher #(.MIN_BODY(MINB)) dut (
    .clk(clk), .rst_n(rst_n), .pad_off(pad_off), .crc_off(crc_off),
    .crc_bad(crc_bad), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int fr_len [NF];
  bit fr_pdis[NF];
  bit fr_cdis[NF];
  bit fr_tog [NF];
  int fr_bad [NF];

  logic [7:0] in_b[$];
  bit         in_l[$];
  int         in_f[$];
  int         in_p[$];
  logic [7:0] ex_b[$];
  bit         ex_l[$];
  int         ex_k[$];
  string      ex_t[$];
  string      ex_lt[$];

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic build(input int f);
    logic [31:0] c;
    logic [7:0]  d;
    int          body;
    string       lt;
    c    = 32'hFFFFFFFF;
    body = fr_len[f];
    if (!fr_pdis[f] && body < MINB) body = MINB;
    if (fr_tog[f])                         lt = "R9";
    else if (fr_pdis[f] && fr_len[f] < MINB) lt = "R3";
    else if (fr_cdis[f])                   lt = "R5";
    else                                   lt = "R7";
    for (int p = 0; p < body; p++) begin
      d = (p < fr_len[f]) ? 8'($urandom) : 8'h00;
      c = ref_crc(c, d);
      if (p < fr_len[f]) begin
        in_b.push_back(d); in_l.push_back(p == fr_len[f]-1);
        in_f.push_back(f); in_p.push_back(p);
      end
      ex_b.push_back(d);
      ex_l.push_back(fr_cdis[f] && p == body-1);
      ex_k.push_back(p < fr_len[f] ? 0 : 1);
      ex_t.push_back(fr_tog[f] ? "R9" : (p < fr_len[f] ? "R1" : "R2"));
      ex_lt.push_back(lt);
    end
    if (!fr_cdis[f]) begin
      c = (fr_bad[f] >= 0) ? c : ~c;
      for (int k = 0; k < 4; k++) begin
        ex_b.push_back(c[8*k +: 8]);
        ex_l.push_back(k == 3);
        ex_k.push_back(2);
        ex_t.push_back(fr_tog[f] ? "R9" : (fr_bad[f] >= 0 ? "R6" : "R4"));
        ex_lt.push_back(lt);
      end
    end
  endtask

  task automatic setf(input int f, input int len, input bit pd, input bit cd,
                      input bit tg, input int bd);
    fr_len[f] = len; fr_pdis[f] = pd; fr_cdis[f] = cd; fr_tog[f] = tg; fr_bad[f] = bd;
  endtask

  initial begin
    int ip, op, cyc, f, p, seed;
    bit acc, stall_prev;
    logic [7:0] prev_d;
    seed = $urandom(32'd20240611);

    // Directed corner frames, then random ones.
    setf(0, 1, 0, 0, 0, -1);    // padded to 60, plus CRC (R2, R4)
    setf(1, 59, 0, 0, 0, -1);   // one pad byte
    setf(2, 60, 0, 0, 0, -1);   // exactly minimum, no pad
    setf(3, 61, 0, 0, 0, -1);   // above minimum
    setf(4, 3, 1, 1, 0, -1);    // runt, nothing appended (R3, R5)
    setf(5, 5, 1, 0, 0, -1);    // runt with CRC (R3)
    setf(6, 10, 0, 1, 0, -1);   // padded, no CRC (R5)
    setf(7, 20, 0, 0, 0, 2);    // spoiled CRC (R6)
    setf(8, 8, 0, 0, 1, -1);    // options flipped mid-frame (R9)
    setf(9, 1, 1, 1, 0, -1);    // single byte, last on data (R7)
    setf(10, 30, 1, 0, 0, 29);  // spoiled on final byte, unpadded (R6)
    setf(11, 12, 1, 1, 1, -1);  // flip the other way (R9)
    for (int i = 12; i < NF; i++) begin
      setf(i, 1 + int'($urandom % 100), bit'($urandom % 3 == 0), bit'($urandom % 3 == 0),
           bit'($urandom % 8 == 0), -1);
      if ($urandom % 6 == 0) fr_bad[i] = int'($urandom % 32'(fr_len[i]));
      if (fr_cdis[i]) fr_bad[i] = -1;
    end
    for (int i = 0; i < NF; i++) build(i);

    // Reset phase: inputs active, block must stay quiet (R10).
    rst_n = 1'b0; in_valid = 1'b1; out_ready = 1'b1; in_data = 8'h00;
    in_last = 1'b0; pad_off = 1'b0; crc_off = 1'b0; crc_bad = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chk(!in_ready, "R10", "in_ready during reset", in_ready, 0);
    chk(!out_valid, "R10", "out_valid during reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!in_ready && !out_valid, "R10", "quiet during release", {in_ready, out_valid}, 0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);

    ip = 0; op = 0; cyc = 0; acc = 1'b0; stall_prev = 1'b0; prev_d = 8'h00;
    while (op < ex_b.size() && cyc < WD) begin
      @(negedge clk);
      cyc++;
      if (acc) in_valid = 1'b0;
      acc = 1'b0;
      if (ip < in_b.size()) begin
        if (!in_valid) in_valid = ($urandom % 4) != 0;
        f = in_f[ip]; p = in_p[ip];
        in_data = in_b[ip]; in_last = in_l[ip];
        pad_off = fr_pdis[f] ^ (fr_tog[f] && p > 0);
        crc_off = fr_cdis[f] ^ (fr_tog[f] && p > 0);
        crc_bad = (p == fr_bad[f]);
      end else begin
        in_valid = 1'b0; in_last = 1'b0; crc_bad = 1'b0;
      end
      out_ready = (($urandom % 100) < (((cyc / 200) % 3 == 0) ? 40 : 85));
      #2;
      if (stall_prev) begin
        chk(out_valid && out_data == prev_d, "R8", "stalled byte held",
            {out_valid, out_data}, {1'b1, prev_d});
      end
      stall_prev = out_valid && !out_ready && ex_k[op] != 0;
      prev_d     = out_data;
      if (in_valid && in_ready) begin
        ip++; acc = 1'b1;
        if (op < ex_b.size() && ex_k[op] == 0)
          chk(out_valid && out_ready, "R8", "data handshake passes through",
              {out_valid, out_ready}, 3);
      end
      if (out_valid && out_ready) begin
        chk(out_data == ex_b[op], ex_t[op], $sformatf("byte %0d", op), out_data, ex_b[op]);
        chk(out_last == ex_l[op], ex_lt[op], $sformatf("last flag at byte %0d", op),
            out_last, ex_l[op]);
        op++;
      end
    end
    chk(cyc < WD, "WD", "watchdog expired", cyc, WD);
    chk(ip == in_b.size(), "R1", "all input bytes accepted", ip, in_b.size());
    repeat (3) begin
      @(negedge clk);
      out_ready = 1'b1;
      #2;
      chk(!out_valid, "R7", "no byte after final frame", out_valid, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule